// File: doc/BRIEF.md
# Stack Frame Link/Unlink Sequencer

This block carries out the three stack-frame commands of a processor core: building a frame (link with a signed displacement), tearing a frame down (unlink), and pushing a computed address onto the stack. It works on a copy of the stack pointer and of one selected address register, both captured when a command is accepted. It runs one 32-bit memory cycle per command over a simple request/acknowledge port. When it finishes it returns the updated pair of registers with a one-clock completion pulse.

The sequencer is a single state machine with eleven named states. `ST_IDLE` waits for a command. Link runs `ST_LK_DEC` (stack pointer minus 4), `ST_LK_WR` (write the old register value at the new stack pointer, held until acknowledge), `ST_LK_CPY` (register takes the stack pointer) and `ST_LK_ADJ` (stack pointer plus displacement). Unlink runs `ST_UL_LD` (stack pointer takes the register), `ST_UL_RD` (read at the stack pointer into the register, held until acknowledge) and `ST_UL_INC` (stack pointer plus 4). Push runs `ST_PU_DEC` and `ST_PU_WR`. Every sequence then passes through `ST_DONE`, which raises the completion pulse, and returns to `ST_IDLE`. The transitions are: idle to the first step of the command on acceptance; each register step to the next step unconditionally; each memory step to the next step only on acknowledge; `ST_DONE` to `ST_IDLE` unconditionally.

The caller may flag that the selected address register is the stack pointer itself. In that case the block treats both copies as one register: every write to either lands in both, so the last write in the sequence decides the result.

Top module: `frame_seq_top`

## Requirements
- R1: After reset, busy, done and mem_req are 0 and sp_out and areg_out are 0.
- R2: cmd_op encodes 2'b01 link, 2'b10 unlink, 2'b11 push, 2'b00 no operation. A valid non-zero command is accepted only when busy is 0, and busy is 1 from the next cycle. A 2'b00 command leaves busy at 0 and starts no memory cycle.
- R3: Link performs exactly one memory write, at address sp_in-4, with data equal to the pre-command value of the selected register.
- R4: Link ends with areg_out = sp_in-4 and sp_out = sp_in-4+D. D is disp when disp_long is 1, and disp[15:0] sign-extended to 32 bits when disp_long is 0.
- R5: Unlink performs exactly one memory read, at address areg_in. It ends with areg_out equal to the read data and sp_out = areg_in+4.
- R6: Push performs exactly one memory write of push_addr at address sp_in-4. It ends with sp_out = sp_in-4 and areg_out = areg_in.
- R7: With areg_is_sp set, areg_in is ignored and every write reaches both registers. Link writes sp_in at sp_in-4 and ends with both outputs equal to sp_in-4+D. Unlink reads at sp_in and ends with both outputs equal to the read data plus 4. Push ends with both outputs equal to sp_in-4.
- R8: While mem_req is 1 and mem_ack is 0, mem_req, mem_we, mem_addr and mem_wdata hold their values. mem_we is 1 for writes and 0 for reads.
- R9: done is a one-cycle pulse. The number of clock edges from the edge after acceptance to the edge that raises done is 4 for link, 3 for unlink and 2 for push, plus one per cycle of acknowledge wait. busy is 0 in the cycle after done.
- R10: Commands presented while busy is 1 are ignored and do not change the running sequence or its results.
- R11: sp_out and areg_out change only at the steps named. Throughout every memory cycle, sp_out equals mem_addr and neither output changes while waiting for acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code (see R2) |
| disp | input | 32 | Link displacement |
| disp_long | input | 1 | 1: full 32-bit displacement, 0: low 16 bits sign-extended |
| push_addr | input | 32 | Address to push |
| sp_in | input | 32 | Stack pointer value at command time |
| areg_in | input | 32 | Selected address register value at command time |
| areg_is_sp | input | 1 | Selected register is the stack pointer |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 32 | Working/updated stack pointer |
| areg_out | output | 32 | Working/updated address register |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Memory longword address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Memory cycle acknowledge |

## Verification
The result of a command is due on a fixed edge: 4, 3 or 2 edges after the acceptance edge for link, unlink and push. Each cycle in which the memory model holds back its acknowledge adds one edge. The bench counts these edges at falling clock edges, compares the count against that sum, and only then compares sp_out, areg_out and the recorded memory cycle with values from its own model. The memory model raises acknowledge on falling edges after a random delay of 0 to 3 cycles. At the moment it acknowledges, it checks that sp_out equals the request address. One falling edge after done, the bench checks that done and busy have both dropped.

// File: rtl/frame_pkg.sv
package frame_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_LINK = 2'b01,
        OP_UNLK = 2'b10,
        OP_PUSH = 2'b11
    } fop_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LK_DEC,
        ST_LK_WR,
        ST_LK_CPY,
        ST_LK_ADJ,
        ST_UL_LD,
        ST_UL_RD,
        ST_UL_INC,
        ST_PU_DEC,
        ST_PU_WR,
        ST_DONE
    } fst_e;

    // one-hot-ish register transfer strobes issued by the controller
    typedef struct packed {
        logic load;        // capture command operands
        logic load_push;   // the captured command is a push
        logic sp_dec;      // sp <- sp - step
        logic sp_inc;      // sp <- sp + step
        logic sp_disp;     // sp <- sp + displacement
        logic sp_from_ar;  // sp <- ar
        logic ar_from_sp;  // ar <- sp
        logic ar_from_rd;  // ar <- memory read data
    } fstep_t;

endpackage

// File: rtl/frame_ctrl.sv
module frame_ctrl
    import frame_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic   mem_ack,
    output fst_e   state,
    output fstep_t step,
    output logic   busy,
    output logic   done
);

    fst_e state_q;
    fst_e state_d;
    fop_e op_w;

    assign op_w  = fop_e'(cmd_op);
    assign state = state_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        step    = '0;
        busy    = 1'b1;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                if (cmd_valid && op_w != OP_NONE) begin
                    step.load      = 1'b1;
                    step.load_push = (op_w == OP_PUSH);
                    unique case (op_w)
                        OP_LINK: state_d = ST_LK_DEC;
                        OP_UNLK: state_d = ST_UL_LD;
                        OP_PUSH: state_d = ST_PU_DEC;
                        default: state_d = ST_IDLE;
                    endcase
                end
            end
            ST_LK_DEC: begin
                step.sp_dec = 1'b1;
                state_d     = ST_LK_WR;
            end
            ST_LK_WR: begin
                if (mem_ack) state_d = ST_LK_CPY;
            end
            ST_LK_CPY: begin
                step.ar_from_sp = 1'b1;
                state_d         = ST_LK_ADJ;
            end
            ST_LK_ADJ: begin
                step.sp_disp = 1'b1;
                state_d      = ST_DONE;
            end
            ST_UL_LD: begin
                step.sp_from_ar = 1'b1;
                state_d         = ST_UL_RD;
            end
            ST_UL_RD: begin
                if (mem_ack) begin
                    step.ar_from_rd = 1'b1;
                    state_d         = ST_UL_INC;
                end
            end
            ST_UL_INC: begin
                step.sp_inc = 1'b1;
                state_d     = ST_DONE;
            end
            ST_PU_DEC: begin
                step.sp_dec = 1'b1;
                state_d     = ST_PU_WR;
            end
            ST_PU_WR: begin
                if (mem_ack) state_d = ST_DONE;
            end
            ST_DONE: begin
                done    = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/frame_regs.sv
module frame_regs
    import frame_pkg::*;
#(
    parameter int AW      = 32,
    parameter int SHORT_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fstep_t        step,
    input  logic [AW-1:0] sp_in,
    input  logic [AW-1:0] areg_in,
    input  logic          alias_in,
    input  logic [AW-1:0] disp_in,
    input  logic          disp_long_in,
    input  logic [AW-1:0] push_in,
    input  logic [AW-1:0] rd_data,
    output logic [AW-1:0] sp_q,
    output logic [AW-1:0] ar_q,
    output logic [AW-1:0] wdat_q,
    output logic          alias_q
);

    localparam int          STEP_BYTES = AW / 8;
    localparam logic [AW-1:0] STEP_V   = AW'(STEP_BYTES);

    logic [AW-1:0] disp_q;
    logic [AW-1:0] disp_ext;
    logic [AW-1:0] ar_src;
    logic [AW-1:0] sp_n, ar_n;
    logic          sp_w, ar_w;

    // displacement width variant chosen by parameter
    generate
        if (SHORT_W < AW) begin : g_sext
            assign disp_ext = disp_long_in ? disp_in
                            : {{(AW-SHORT_W){disp_in[SHORT_W-1]}}, disp_in[SHORT_W-1:0]};
        end else begin : g_full
            assign disp_ext = disp_in;
        end
    endgenerate

    assign ar_src = alias_in ? sp_in : areg_in;

    // register transfers with aliasing merge
    always_comb begin
        sp_n = sp_q;
        ar_n = ar_q;
        sp_w = 1'b0;
        ar_w = 1'b0;
        if (step.sp_dec)     begin sp_n = sp_q - STEP_V; sp_w = 1'b1; end
        if (step.sp_inc)     begin sp_n = sp_q + STEP_V; sp_w = 1'b1; end
        if (step.sp_disp)    begin sp_n = sp_q + disp_q; sp_w = 1'b1; end
        if (step.sp_from_ar) begin sp_n = ar_q;          sp_w = 1'b1; end
        if (step.ar_from_sp) begin ar_n = sp_q;          ar_w = 1'b1; end
        if (step.ar_from_rd) begin ar_n = rd_data;       ar_w = 1'b1; end
        if (alias_q) begin
            if (sp_w) ar_n = sp_n;
            if (ar_w) sp_n = ar_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q    <= '0;
            ar_q    <= '0;
            wdat_q  <= '0;
            disp_q  <= '0;
            alias_q <= 1'b0;
        end else if (step.load) begin
            sp_q    <= sp_in;
            ar_q    <= ar_src;
            wdat_q  <= step.load_push ? push_in : ar_src;
            disp_q  <= disp_ext;
            alias_q <= alias_in;
        end else begin
            sp_q <= sp_n;
            ar_q <= ar_n;
        end
    end

endmodule

// File: rtl/frame_memif.sv
module frame_memif
    import frame_pkg::*;
#(
    parameter int AW = 32
) (
    input  fst_e          state,
    input  logic [AW-1:0] sp_q,
    input  logic [AW-1:0] wdat_q,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata
);

    always_comb begin
        mem_req = 1'b0;
        mem_we  = 1'b0;
        unique case (state)
            ST_LK_WR, ST_PU_WR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_UL_RD: begin
                mem_req = 1'b1;
            end
            default: begin
                mem_req = 1'b0;
            end
        endcase
    end

    // every memory cycle is addressed by the working stack pointer
    assign mem_addr  = sp_q;
    assign mem_wdata = wdat_q;

endmodule

// File: rtl/frame_seq_top.sv
module frame_seq_top
    import frame_pkg::*;
#(
    parameter int AW      = 32,
    parameter int SHORT_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [AW-1:0] disp,
    input  logic          disp_long,
    input  logic [AW-1:0] push_addr,
    input  logic [AW-1:0] sp_in,
    input  logic [AW-1:0] areg_in,
    input  logic          areg_is_sp,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] sp_out,
    output logic [AW-1:0] areg_out,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    input  logic [AW-1:0] mem_rdata,
    input  logic          mem_ack
);

    fst_e          state_w;
    fstep_t        step_w;
    logic [AW-1:0] wdat_w;
    logic          alias_w;

    frame_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .mem_ack   (mem_ack),
        .state     (state_w),
        .step      (step_w),
        .busy      (busy),
        .done      (done)
    );

    frame_regs #(.AW(AW), .SHORT_W(SHORT_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .step         (step_w),
        .sp_in        (sp_in),
        .areg_in      (areg_in),
        .alias_in     (areg_is_sp),
        .disp_in      (disp),
        .disp_long_in (disp_long),
        .push_in      (push_addr),
        .rd_data      (mem_rdata),
        .sp_q         (sp_out),
        .ar_q         (areg_out),
        .wdat_q       (wdat_w),
        .alias_q      (alias_w)
    );

    frame_memif #(.AW(AW)) u_mem (
        .state     (state_w),
        .sp_q      (sp_out),
        .wdat_q    (wdat_w),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [1:0]    cmd_op,
    input logic          busy,
    input logic          done,
    input logic [AW-1:0] sp_out,
    input logic [AW-1:0] areg_out,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] mem_wdata,
    input logic          mem_ack,
    input logic          alias_q
);

    a_r2_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && cmd_op != 2'b00) |=> busy);

    a_r2_noop_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (!cmd_valid || cmd_op == 2'b00)) |=> !busy);

    a_r8_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_wdata) && $stable(mem_we)));

    a_r8_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r10_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    a_r11_regs_hold_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> ($stable(sp_out) && $stable(areg_out)));

    a_r11_addr_is_sp: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr == sp_out));

    a_r7_alias_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (done && alias_q) |-> (sp_out == areg_out));

endmodule

bind frame_seq_top frame_seq_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .busy      (busy),
    .done      (done),
    .sp_out    (sp_out),
    .areg_out  (areg_out),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .alias_q   (alias_w)
);

// File: tb/tb_frame_seq_top.sv
module tb_frame_seq_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [31:0] disp, push_addr, sp_in, areg_in;
    logic        disp_long, areg_is_sp;
    logic        busy, done, mem_req, mem_we;
    logic [31:0] sp_out, areg_out, mem_addr, mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ack;

    int n_vec = 0;
    int n_bad = 0;
    int mem_n, waits, wait_cnt;
    logic [31:0] m_addr, m_data;
    logic        m_we;

    always #4 clk = ~clk;

    frame_seq_top dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .disp(disp), .disp_long(disp_long), .push_addr(push_addr),
        .sp_in(sp_in), .areg_in(areg_in), .areg_is_sp(areg_is_sp),
        .busy(busy), .done(done), .sp_out(sp_out), .areg_out(areg_out),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    function automatic logic [31:0] rd_fn(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A3C_96E0;
    endfunction

    function automatic logic [31:0] dext(input logic [31:0] d, input logic lng);
        return lng ? d : {{16{d[15]}}, d[15:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model: acknowledges on falling edges after a random wait
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack   = 1'b0;
            mem_rdata = '0;
            wait_cnt  = 0;
        end else if (mem_req && !mem_ack) begin
            if (wait_cnt == 0) begin
                mem_ack   = 1'b1;
                mem_n++;
                m_addr    = mem_addr;
                m_we      = mem_we;
                m_data    = mem_wdata;
                mem_rdata = rd_fn(mem_addr);
                chk("R11 sp_out equals mem_addr", sp_out, mem_addr);
            end else begin
                wait_cnt--;
                waits++;
            end
        end else begin
            mem_ack  = 1'b0;
            wait_cnt = int'($urandom % 4);
        end
    end

    task automatic run_cmd(input logic [1:0] op, input logic [31:0] sp, input logic [31:0] ar,
                           input logic al, input logic [31:0] d, input logic dl,
                           input logic [31:0] pa, input logic poke);
        int cnt;
        int steps;
        logic [31:0] e_sp, e_ar, e_addr, e_data, nsp, base, rd, dx;
        logic        e_we;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; sp_in = sp; areg_in = ar; areg_is_sp = al;
        disp = d; disp_long = dl; push_addr = pa;
        mem_n = 0; waits = 0;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R2 busy after accept", 32'(busy), 32'd1);
        cnt = 0;
        while (!done && cnt < 200) begin
            @(negedge clk);
            cnt++;
            if (poke && cnt == 1) begin
                // R10: a command while busy, with all operands disturbed
                cmd_valid = 1'b1; cmd_op = 2'b11; sp_in = ~sp; areg_in = ~ar;
                push_addr = ~pa; disp = ~d; areg_is_sp = ~al;
            end else begin
                cmd_valid = 1'b0;
            end
        end
        dx  = dext(d, dl);
        nsp = sp - 32'd4;
        unique case (op)
            2'b01: begin
                steps = 4; e_we = 1'b1; e_addr = nsp; e_data = al ? sp : ar;
                e_sp = nsp + dx; e_ar = al ? nsp + dx : nsp;
            end
            2'b10: begin
                steps = 3; e_we = 1'b0; base = al ? sp : ar; rd = rd_fn(base);
                e_addr = base; e_data = 32'd0;
                e_ar = al ? rd + 32'd4 : rd; e_sp = al ? rd + 32'd4 : base + 32'd4;
            end
            default: begin
                steps = 2; e_we = 1'b1; e_addr = nsp; e_data = pa;
                e_sp = nsp; e_ar = al ? nsp : ar;
            end
        endcase
        chk("R9 done latency", 32'(cnt), 32'(steps + waits));
        // R3 R5 R6 R10: one memory cycle with the right address and direction
        chk("R10 memory cycle count", 32'(mem_n), 32'd1);
        chk("R8 mem_we", 32'(m_we), 32'(e_we));
        chk(op == 2'b01 ? "R3 link address" : (op == 2'b10 ? "R5 unlink address" : "R6 push address"),
            m_addr, e_addr);
        if (e_we) chk(op == 2'b01 ? "R3 link data" : "R6 push data", m_data, e_data);
        if (al) begin
            chk("R7 alias sp_out", sp_out, e_sp);
            chk("R7 alias areg_out", areg_out, e_ar);
        end else begin
            chk(op == 2'b01 ? "R4 link sp_out" : (op == 2'b10 ? "R5 unlink sp_out" : "R6 push sp_out"),
                sp_out, e_sp);
            chk(op == 2'b01 ? "R4 link areg_out" : (op == 2'b10 ? "R5 unlink areg_out" : "R6 push areg_out"),
                areg_out, e_ar);
        end
        @(negedge clk);
        chk("R9 done one cycle", 32'(done), 32'd0);
        chk("R9 busy dropped", 32'(busy), 32'd0);
    endtask

    initial begin : wd
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL R9 watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00; disp = '0; disp_long = 1'b0;
        push_addr = '0; sp_in = '0; areg_in = '0; areg_is_sp = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 mem_req", 32'(mem_req), 32'd0);
        chk("R1 sp_out", sp_out, 32'd0);
        chk("R1 areg_out", areg_out, 32'd0);

        // R2: a no-operation code is ignored
        mem_n = 0;
        cmd_valid = 1'b1; cmd_op = 2'b00; sp_in = 32'h1000;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 no-op leaves idle", 32'(busy), 32'd0);
        chk("R2 no-op no memory cycle", 32'(mem_n), 32'd0);
        chk("R2 no-op keeps sp_out", sp_out, 32'd0);

        // directed corners
        run_cmd(2'b01, 32'h0000_2000, 32'hA000_0010, 1'b0, 32'h0000_8000, 1'b0, 32'h0, 1'b0); // R4 most negative short
        run_cmd(2'b01, 32'h0000_2000, 32'hA000_0010, 1'b0, 32'hFFFE_0000, 1'b1, 32'h0, 1'b0); // R4 long
        run_cmd(2'b01, 32'h0000_3000, 32'h1234_5678, 1'b1, 32'h0000_FFF0, 1'b0, 32'h0, 1'b0); // R7 link alias
        run_cmd(2'b10, 32'h0000_3000, 32'h0000_4000, 1'b1, 32'h0, 1'b0, 32'h0, 1'b0);         // R7 unlink alias
        run_cmd(2'b11, 32'h0000_3000, 32'h0000_4000, 1'b1, 32'h0, 1'b0, 32'hDEAD_BEE0, 1'b0); // R7 push alias
        run_cmd(2'b11, 32'h0000_0000, 32'h0000_4000, 1'b0, 32'h0, 1'b0, 32'h0BAD_F00D, 1'b1); // R6 wrap, R10
        run_cmd(2'b10, 32'h0000_5000, 32'hFFFF_FFFC, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1);         // R5 wrap, R10

        // constrained random
        for (int i = 0; i < 300; i++) begin
            logic [1:0] op;
            op = 2'(1 + ($urandom % 3));
            run_cmd(op, $urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC,
                    ($urandom % 5) == 0, $urandom, 1'($urandom % 2),
                    $urandom, ($urandom % 3) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule